// File: doc/BRIEF.md
# Interrupt Flag and Enable Controller

This block gathers one-cycle event pulses from seven internal sources (card detect, timer, transmit done, receive done, idle, FIFO high alert and FIFO low alert) into a pending-flag register. A second register holds one enable bit per source. Any flag that is pending and enabled drives a level-sensitive interrupt pin, whose active polarity is a build parameter. The same condition is also reported as a summary bit in a status byte.

The host reaches both registers through a small write and read port. Neither register is overwritten directly. Bit 7 of the write data chooses the operation: when it is 1, every bit written as 1 is set, and when it is 0, every bit written as 1 is cleared. Bits written as 0 are left alone. Hardware events only ever set flags, and only the host changes the enables.

Top module: `evt_irq_hub`

## Requirements
- R1: After reset, all flags and all enables are 0, the summary is 0, the pin is inactive, and every readable address returns 0.
- R2: A one-cycle pulse on `evt_i[k]` sets flag bit k at the next clock edge. The flag stays set until the host clears it. The bit map is: 6 card detect, 5 timer, 4 transmit, 3 receive, 2 idle, 1 FIFO high alert, 0 FIFO low alert.
- R3: A write to address 0 with data bit 7 = 1 sets each flag whose data bit is 1 and leaves the other flags unchanged.
- R4: A write to address 0 with data bit 7 = 0 clears each flag whose data bit is 1 and leaves the other flags unchanged.
- R5: When an event and a host clear reach the same flag in the same cycle, the flag ends up set.
- R6: Address 1 holds the enables, which use the same bit-7 set/clear rule. Events never change the enables. Writes to address 2 or 3 change neither register.
- R7: The pin is active when any bit of (flags AND enables) is 1. With `IRQ_ACT_HIGH` = 1, active means 1; with `IRQ_ACT_HIGH` = 0, active means 0.
- R8: Address 2 reads a status byte whose bit 3 is the summary (OR of flags AND enables), with all other bits 0. `irq_sum_o` carries the same summary.
- R9: Bit 7 reads as 0 at addresses 0 and 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 7 | One-cycle event pulses, one per source |
| host_wr | input | 1 | Write strobe |
| host_addr | input | 2 | Register address: 0 flags, 1 enables, 2 status |
| host_wdata | input | 8 | Write data; bit 7 selects set (1) or clear (0) |
| host_rdata | output | 8 | Read data for `host_addr` |
| irq_o | output | 1 | Level interrupt pin, polarity set by parameter |
| irq_sum_o | output | 1 | Summary of pending and enabled sources |

## Verification
The bench builds two copies of the block with the default seven sources. One copy uses an active-high pin and the other an active-low pin. Both are driven by the same stimulus, so both generate variants of the pin stage are checked against the same flag and enable state. Events that coincide with a host clear are applied on the same clock edge as the write, which exercises the priority of hardware set over host clear.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
   localparam int unsigned REG_W      = 8;
   localparam int unsigned SRC_N      = 7;
   localparam int unsigned OP_BIT     = 7;
   localparam int unsigned SUM_BIT    = 3;
   localparam logic [1:0]  A_FLAGS    = 2'd0;
   localparam logic [1:0]  A_ENABLES  = 2'd1;
   localparam logic [1:0]  A_STATUS   = 2'd2;

   typedef enum logic [2:0] {
      SRC_FIFO_LO = 3'd0,
      SRC_FIFO_HI = 3'd1,
      SRC_IDLE    = 3'd2,
      SRC_RX      = 3'd3,
      SRC_TX      = 3'd4,
      SRC_TIMER   = 3'd5,
      SRC_CARD    = 3'd6
   } src_e;
endpackage

// File: rtl/setclr_reg.sv
module setclr_reg #(
   parameter int unsigned W = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic         op_set,
   input  logic [W-1:0] mask,
   input  logic [W-1:0] hw_set,
   output logic [W-1:0] q
);
   logic [W-1:0] q_r;

   for (genvar b = 0; b < W; b++) begin : g_bit
      logic nxt;
      always_comb begin
         nxt = q_r[b];
         if (wr && mask[b]) nxt = op_set;
         if (hw_set[b])     nxt = 1'b1;   // hardware set has priority
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q_r[b] <= 1'b0;
         else        q_r[b] <= nxt;
      end
   end

   assign q = q_r;
endmodule

// File: rtl/irq_merge.sv
module irq_merge #(
   parameter int unsigned N        = 7,
   parameter bit          ACT_HIGH = 1'b1
) (
   input  logic [N-1:0] flags,
   input  logic [N-1:0] enables,
   output logic         any,
   output logic         pin
);
   assign any = |(flags & enables);

   if (ACT_HIGH) begin : g_hi
      assign pin = any;
   end else begin : g_lo
      assign pin = ~any;
   end
endmodule

// File: rtl/evt_irq_hub.sv
module evt_irq_hub
   import evt_irq_pkg::*;
#(
   parameter int unsigned NUM_SRC      = SRC_N,
   parameter int unsigned DATA_W       = REG_W,
   parameter bit          IRQ_ACT_HIGH = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_SRC-1:0] evt_i,
   input  logic              host_wr,
   input  logic [1:0]        host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic              irq_o,
   output logic              irq_sum_o
);
   localparam int unsigned PAD_W = DATA_W - NUM_SRC;

   if (DATA_W != NUM_SRC + 1) begin : g_bad_width
      $error("evt_irq_hub: DATA_W must be NUM_SRC + 1");
   end
   if (SUM_BIT >= DATA_W) begin : g_bad_sum
      $error("evt_irq_hub: summary bit outside data width");
   end

   logic [NUM_SRC-1:0] flag_q, en_q;
   logic               wr_flags, wr_en, op_set, sum;

   assign op_set   = host_wdata[DATA_W-1];
   assign wr_flags = host_wr && (host_addr == A_FLAGS);
   assign wr_en    = host_wr && (host_addr == A_ENABLES);

   setclr_reg #(.W(NUM_SRC)) u_flags (
      .clk(clk), .rst_n(rst_n), .wr(wr_flags), .op_set(op_set),
      .mask(host_wdata[NUM_SRC-1:0]), .hw_set(evt_i), .q(flag_q)
   );

   setclr_reg #(.W(NUM_SRC)) u_enables (
      .clk(clk), .rst_n(rst_n), .wr(wr_en), .op_set(op_set),
      .mask(host_wdata[NUM_SRC-1:0]), .hw_set('0), .q(en_q)
   );

   irq_merge #(.N(NUM_SRC), .ACT_HIGH(IRQ_ACT_HIGH)) u_merge (
      .flags(flag_q), .enables(en_q), .any(sum), .pin(irq_o)
   );

   assign irq_sum_o = sum;

   always_comb begin
      host_rdata = '0;
      unique case (host_addr)
         A_FLAGS:   host_rdata = {{PAD_W{1'b0}}, flag_q};
         A_ENABLES: host_rdata = {{PAD_W{1'b0}}, en_q};
         A_STATUS:  host_rdata[SUM_BIT] = sum;
         default:   host_rdata = '0;
      endcase
   end
endmodule

// File: rtl/evt_irq_hub_chk.sv
module evt_irq_hub_chk #(
   parameter int unsigned NUM_SRC  = 7,
   parameter int unsigned DATA_W   = 8,
   parameter bit          ACT_HIGH = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SRC-1:0] evt_i,
   input logic               host_wr,
   input logic [1:0]         host_addr,
   input logic [DATA_W-1:0]  host_wdata,
   input logic [NUM_SRC-1:0] flag_q,
   input logic [NUM_SRC-1:0] en_q,
   input logic               irq_o
);
   // R2: an event pulse is visible as a set flag on the next cycle
   a_r2_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i != '0) |=> ((flag_q & $past(evt_i)) == $past(evt_i)));

   // R4: a clear write with no coinciding event empties the written bits
   a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && host_addr == 2'd0 && !host_wdata[DATA_W-1] && evt_i == '0)
      |=> ((flag_q & $past(host_wdata[NUM_SRC-1:0])) == '0));

   // R3: a set write fills the written bits
   a_r3_set: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && host_addr == 2'd0 && host_wdata[DATA_W-1])
      |=> ((flag_q & $past(host_wdata[NUM_SRC-1:0])) == $past(host_wdata[NUM_SRC-1:0])));

   // R6: enables move only on a host write to address 1
   a_r6_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(host_wr && host_addr == 2'd1) |=> $stable(en_q));

   // R7: pin level follows pending-and-enabled with the chosen polarity
   a_r7_pin: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == (((flag_q & en_q) != '0) ~^ ACT_HIGH));
endmodule

bind evt_irq_hub evt_irq_hub_chk #(
   .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ACT_HIGH(IRQ_ACT_HIGH)
) i_chk (
   .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .host_wr(host_wr),
   .host_addr(host_addr), .host_wdata(host_wdata),
   .flag_q(flag_q), .en_q(en_q), .irq_o(irq_o)
);

// File: tb/test_evt_irq_hub.sv
`timescale 1ns/1ps
module test_evt_irq_hub;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [6:0] evt_i = '0;
   logic       host_wr = 1'b0;
   logic [1:0] host_addr = '0;
   logic [7:0] host_wdata = '0;
   logic [7:0] rdata_h, rdata_l;
   logic       irq_h, irq_l, sum_h, sum_l;
   int         n_chk = 0;
   int         n_bad = 0;

   always #4 clk = ~clk;

   evt_irq_hub #(.IRQ_ACT_HIGH(1'b1)) i_evt_irq_hub (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .host_wr(host_wr),
      .host_addr(host_addr), .host_wdata(host_wdata),
      .host_rdata(rdata_h), .irq_o(irq_h), .irq_sum_o(sum_h));

   evt_irq_hub #(.IRQ_ACT_HIGH(1'b0)) i_evt_irq_hub_lo (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .host_wr(host_wr),
      .host_addr(host_addr), .host_wdata(host_wdata),
      .host_rdata(rdata_l), .irq_o(irq_l), .irq_sum_o(sum_l));

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   // drive a write (and optional events) for one edge
   task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic [6:0] ev = '0);
      @(negedge clk);
      host_wr = 1'b1; host_addr = a; host_wdata = d; evt_i = ev;
      @(negedge clk);
      host_wr = 1'b0; host_wdata = '0; evt_i = '0;
   endtask

   task automatic pulse(input logic [6:0] ev);
      @(negedge clk);
      evt_i = ev;
      @(negedge clk);
      evt_i = '0;
   endtask

   task automatic rd(input string req, input logic [1:0] a, input logic [7:0] exp);
      host_addr = a;
      #1;
      check(req, rdata_h, exp);
      check(req, rdata_l, exp);
   endtask

   task automatic pins(input string req, input logic exp_sum);
      check(req, {7'd0, sum_h}, {7'd0, exp_sum});
      check(req, {7'd0, irq_h}, {7'd0, exp_sum});
      check(req, {7'd0, irq_l}, {7'd0, ~exp_sum});
   endtask

   task automatic t_reset;
      rd("R1 flags", 2'd0, 8'h00);
      rd("R1 enables", 2'd1, 8'h00);
      rd("R1 status", 2'd2, 8'h00);
      rd("R1 addr3", 2'd3, 8'h00);
      pins("R1 pin", 1'b0);
   endtask

   task automatic t_events;
      pulse(7'b100_0001);
      rd("R2 card+lo", 2'd0, 8'h41);
      @(negedge clk);
      rd("R2 held", 2'd0, 8'h41);
      pins("R7 disabled", 1'b0);
   endtask

   task automatic t_setclr;
      wr(2'd0, 8'h86);
      rd("R3 set", 2'd0, 8'h47);
      wr(2'd0, 8'h41);
      rd("R4 clear", 2'd0, 8'h06);
      wr(2'd0, 8'hFF);
      rd("R9 bit7 flags", 2'd0, 8'h7F);
   endtask

   task automatic t_enables;
      wr(2'd1, 8'h84);
      rd("R6 en set", 2'd1, 8'h04);
      pins("R7 enabled", 1'b1);
      rd("R8 status", 2'd2, 8'h08);
      wr(2'd1, 8'h04);
      rd("R6 en clear", 2'd1, 8'h00);
      pins("R7 off", 1'b0);
      rd("R8 status off", 2'd2, 8'h00);
      pulse(7'h7F);
      rd("R6 events ignored", 2'd1, 8'h00);
      wr(2'd1, 8'hFF);
      rd("R9 bit7 en", 2'd1, 8'h7F);
      wr(2'd2, 8'h7F);
      wr(2'd3, 8'h7F);
      rd("R6 addr2/3 flags", 2'd0, 8'h7F);
      rd("R6 addr2/3 en", 2'd1, 8'h7F);
   endtask

   task automatic t_collide;
      wr(2'd0, 8'h7F, 7'h10);
      rd("R5 hw wins", 2'd0, 8'h10);
      pins("R7 tx pending", 1'b1);
      wr(2'd0, 8'h10);
      rd("R4 last clear", 2'd0, 8'h00);
      pins("R7 none", 1'b0);
   endtask

   initial begin
      #(8 * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_events();
      t_setclr();
      t_enables();
      t_collide();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule